// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 32 pins. Software selects a direction per pin and changes output levels through a pair of write-one registers, one that raises bits and one that lowers them. Bits written as zero are left alone, so two agents can drive different pins without a read-modify-write race. Pin levels are synchronized to the block clock and can be read back at any time, including on pins that are driving.

Each pin can watch for rising edges, falling edges, or both. Detection is armed and disarmed through set/clear register pairs. A detected edge sets a bit in a status register that software clears by writing one. Status is folded into one interrupt line per group of 16 pins, and each line is passed out only while its bit in a bank enable register is set. Access is through a simple register bus: address, write strobe, write data, and combinational read data.

Top module: `gpio_edge_bank`

## Requirements
- R1: Register 0x10 holds the direction, one bit per pin (pin n is bit n), where 1 means input and 0 means output. pin_oe is its inverse. After reset every pin is an input.
- R2: Writing to 0x18 drives high every output bit that is 1 in the written word. Bits written as 0 keep their level.
- R3: Writing to 0x1C drives low every output bit that is 1 in the written word. Reads of 0x14, 0x18 and 0x1C all return the current output data. Output data resets to zero.
- R4: Register 0x20 returns the pin levels through a two-flop synchronizer. This applies to output pins as well. A level change is visible after the second rising clock edge following it.
- R5: Writing ones to 0x24 arms rising-edge detection on those pins, and writing ones to 0x28 disarms it. Reads of either address return the rising-enable mask, which resets to zero.
- R6: Registers 0x2C and 0x30 arm and disarm falling-edge detection in the same way. A pin may have both edges armed at once.
- R7: An armed edge sets status bit n at 0x34 on the third rising clock edge after the pin changes. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Status resets to zero.
- R8: When an armed edge and a clear of the same status bit fall in the same cycle, the bit stays set.
- R9: bank_irq[k] is high exactly when any status bit in pins 16k to 16k+15 is set and bank enable bit k is 1.
- R10: Register 0x08 holds the bank enables in bits [1:0] and resets to zero. While bit k is 0, bank_irq[k] is held low.
- R11: Writes to unmapped addresses and to the read-only registers 0x14 and 0x20 change no state. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pin, 1 = driving |
| bank_irq | output | 2 | One interrupt line per 16-pin bank |

## Verification
On every cycle the assertions check several properties. Pins come out of reset undriven. A set or clear write lands on the outputs in the next cycle. A status bit falls only in a cycle that follows a write-one to it. A bank line is never high without both its enable and a pending status bit in its own 16 pins. The directed scenarios are needed for the rest. They cover the exact synchronizer and edge-detect latency, which edge polarities are armed, edges that are not armed being ignored, the edge winning over a clear in the same cycle, loopback of driven pins into the input register, and writes to read-only and unmapped addresses being ignored.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int GPIO_W   = 32;
    localparam int BANK_W   = 16;
    localparam int ADDR_W   = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_BANK_EN  = 8'h08,
        REG_DIR      = 8'h10,
        REG_OUT      = 8'h14,
        REG_OUT_SET  = 8'h18,
        REG_OUT_CLR  = 8'h1C,
        REG_IN       = 8'h20,
        REG_RISE_SET = 8'h24,
        REG_RISE_CLR = 8'h28,
        REG_FALL_SET = 8'h2C,
        REG_FALL_CLR = 8'h30,
        REG_STAT     = 8'h34
    } reg_sel_e;

    typedef struct packed {
        logic set_en;
        logic clr_en;
    } w1_cmd_t;

    function automatic logic [GPIO_W-1:0] w1_apply(
        input logic [GPIO_W-1:0] cur,
        input w1_cmd_t           cmd,
        input logic [GPIO_W-1:0] mask
    );
        logic [GPIO_W-1:0] nxt;
        nxt = cur;
        if (cmd.set_en) nxt = nxt | mask;
        if (cmd.clr_en) nxt = nxt & ~mask;
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise_evt,
    output logic [W-1:0] fall_evt
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl      = sync_q;
    assign rise_evt = sync_q & ~prev_q;
    assign fall_evt = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_w1_reg.sv
module gpio_w1_reg
    import gpio_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  w1_cmd_t           cmd,
    input  logic [GPIO_W-1:0] mask,
    output logic [GPIO_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= w1_apply(q, cmd, mask);
    end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_eff) | evt;
    end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
    parameter int W      = 32,
    parameter int BANK_W = 16,
    localparam int NB    = W / BANK_W
) (
    input  logic [W-1:0]  status,
    input  logic [NB-1:0] bank_en,
    output logic [NB-1:0] irq
);
    for (genvar k = 0; k < NB; k++) begin : g_bank
        assign irq[k] = bank_en[k] & (|status[k*BANK_W +: BANK_W]);
    end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    localparam int NPINS  = GPIO_W,
    localparam int NBANKS = GPIO_W / BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NBANKS-1:0] bank_irq
);
    logic [NPINS-1:0]  dir_q;
    logic [NBANKS-1:0] bank_en_q;
    logic [NPINS-1:0]  out_q;
    logic [NPINS-1:0]  rise_en_q;
    logic [NPINS-1:0]  fall_en_q;
    logic [NPINS-1:0]  stat_q;
    logic [NPINS-1:0]  in_lvl;
    logic [NPINS-1:0]  rise_evt;
    logic [NPINS-1:0]  fall_evt;
    logic [NPINS-1:0]  hit;
    w1_cmd_t           out_cmd, rise_cmd, fall_cmd;

    function automatic logic wr_to(input logic we, input logic [ADDR_W-1:0] a,
                                   input reg_sel_e r);
        return we && (a == r);
    endfunction

    assign out_cmd  = '{set_en: wr_to(bus_we, bus_addr, REG_OUT_SET),
                        clr_en: wr_to(bus_we, bus_addr, REG_OUT_CLR)};
    assign rise_cmd = '{set_en: wr_to(bus_we, bus_addr, REG_RISE_SET),
                        clr_en: wr_to(bus_we, bus_addr, REG_RISE_CLR)};
    assign fall_cmd = '{set_en: wr_to(bus_we, bus_addr, REG_FALL_SET),
                        clr_en: wr_to(bus_we, bus_addr, REG_FALL_CLR)};

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q     <= '1;
            bank_en_q <= '0;
        end else begin
            if (wr_to(bus_we, bus_addr, REG_DIR))     dir_q     <= bus_wdata;
            if (wr_to(bus_we, bus_addr, REG_BANK_EN)) bank_en_q <= bus_wdata[NBANKS-1:0];
        end
    end

    gpio_w1_reg u_out  (.clk(clk), .rst(rst), .cmd(out_cmd),  .mask(bus_wdata), .q(out_q));
    gpio_w1_reg u_rise (.clk(clk), .rst(rst), .cmd(rise_cmd), .mask(bus_wdata), .q(rise_en_q));
    gpio_w1_reg u_fall (.clk(clk), .rst(rst), .cmd(fall_cmd), .mask(bus_wdata), .q(fall_en_q));

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .lvl(in_lvl), .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    assign hit = (rise_evt & rise_en_q) | (fall_evt & fall_en_q);

    gpio_edge_status #(.W(NPINS)) u_stat (
        .clk(clk), .rst(rst), .evt(hit),
        .clr_en(wr_to(bus_we, bus_addr, REG_STAT)), .clr_mask(bus_wdata),
        .status(stat_q)
    );

    gpio_bank_irq #(.W(NPINS), .BANK_W(BANK_W)) u_irq (
        .status(stat_q), .bank_en(bank_en_q), .irq(bank_irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_BANK_EN:                          bus_rdata[NBANKS-1:0] = bank_en_q;
            REG_DIR:                              bus_rdata = dir_q;
            REG_OUT, REG_OUT_SET, REG_OUT_CLR:    bus_rdata = out_q;
            REG_IN:                               bus_rdata = in_lvl;
            REG_RISE_SET, REG_RISE_CLR:           bus_rdata = rise_en_q;
            REG_FALL_SET, REG_FALL_CLR:           bus_rdata = fall_en_q;
            REG_STAT:                             bus_rdata = stat_q;
            default:                              bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
    import gpio_edge_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int NBANKS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  status,
    input logic [NBANKS-1:0] bank_en,
    input logic [NBANKS-1:0] bank_irq
);
    logic [NPINS-1:0] clr_req;
    logic             set_wr, clr_wr;

    assign clr_req = (bus_we && bus_addr == REG_STAT) ? bus_wdata : '0;
    assign set_wr  = bus_we && bus_addr == REG_OUT_SET;
    assign clr_wr  = bus_we && bus_addr == REG_OUT_CLR;

    a_r1_reset_inputs: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '0));

    a_r2_set_drives_high: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_clear_drives_low: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((pin_out & $past(bus_wdata)) == '0));

    a_r7_status_falls_on_w1c: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~status & ~$past(clr_req)) == '0));

    for (genvar k = 0; k < NBANKS; k++) begin : g_b
        a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
            bank_irq[k] |-> (|status[k*BANK_W +: BANK_W]));
        a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
            !bank_en[k] |-> !bank_irq[k]);
    end
endmodule

bind gpio_edge_bank gpio_edge_chk #(.NPINS(NPINS), .NBANKS(NBANKS)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .status(stat_q), .bank_en(bank_en_q), .bank_irq(bank_irq)
);

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ext = '0;
    logic [31:0] pin_in, pin_out, pin_oe;
    logic [1:0]  bank_irq;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpio_edge_bank u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h10, v); chk("R1 dir reset", v, 32'hFFFF_FFFF);
        chk("R1 oe reset", pin_oe, 32'h0);
        rd(8'h14, v); chk("R3 out reset", v, 32'h0);
        rd(8'h24, v); chk("R5 rise reset", v, 32'h0);
        rd(8'h2C, v); chk("R6 fall reset", v, 32'h0);
        rd(8'h34, v); chk("R7 status reset", v, 32'h0);
        rd(8'h08, v); chk("R10 bank_en reset", v, 32'h0);
        chk("R9 irq reset", {30'h0, bank_irq}, 32'h0);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(8'h10, 32'hFFFF_0000);
        chk("R1 oe low half", pin_oe, 32'h0000_FFFF);
        wr(8'h18, 32'h0000_A5A5); chk("R2 set", pin_out, 32'h0000_A5A5);
        wr(8'h18, 32'h0000_0F00); chk("R2 set keeps", pin_out, 32'h0000_AFA5);
        wr(8'h1C, 32'h0000_00A0); chk("R3 clear", pin_out, 32'h0000_AF05);
        rd(8'h14, v); chk("R3 read 14", v, 32'h0000_AF05);
        rd(8'h18, v); chk("R3 read 18", v, 32'h0000_AF05);
        rd(8'h1C, v); chk("R3 read 1C", v, 32'h0000_AF05);
    endtask

    task automatic t_insync();
        logic [31:0] v;
        wr(8'h18, 32'h2);
        rd(8'h20, v); chk("R4 old after write", v & 32'h2, 32'h0);
        @(negedge clk);
        rd(8'h20, v); chk("R4 old one edge", v & 32'h2, 32'h0);
        @(negedge clk);
        rd(8'h20, v); chk("R4 output loopback", v & 32'h2, 32'h2);
        ext[24] = 1; settle();
        rd(8'h20, v); chk("R4 input pin", v & 32'h0100_0000, 32'h0100_0000);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(8'h24, 32'h0010_0000);
        rd(8'h28, v); chk("R5 read rise mask", v, 32'h0010_0000);
        ext[20] = 1;
        @(negedge clk); @(negedge clk);
        rd(8'h34, v); chk("R7 not yet", v, 32'h0);
        @(negedge clk);
        rd(8'h34, v); chk("R7 rise latched", v, 32'h0010_0000);
        wr(8'h34, 32'h0010_0000);
        ext[20] = 0; settle();
        rd(8'h34, v); chk("R5 falling ignored", v, 32'h0);
    endtask

    task automatic t_fall_both();
        logic [31:0] v;
        wr(8'h2C, 32'h0010_0000);
        ext[20] = 1; settle();
        rd(8'h34, v); chk("R6 both: rise", v, 32'h0010_0000);
        wr(8'h34, 32'h0010_0000);
        ext[20] = 0; settle();
        rd(8'h34, v); chk("R6 both: fall", v, 32'h0010_0000);
        wr(8'h34, 32'h0010_0000);
        wr(8'h28, 32'h0010_0000);
        rd(8'h24, v); chk("R5 disarm", v, 32'h0);
        ext[20] = 1; settle();
        rd(8'h34, v); chk("R6 rise now ignored", v, 32'h0);
        ext[20] = 0; settle();
        rd(8'h34, v); chk("R6 fall only", v, 32'h0010_0000);
        wr(8'h34, 32'h0010_0000);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(8'h24, 32'h0020_0000);
        ext[21] = 1; settle();
        wr(8'h34, 32'h0);
        rd(8'h34, v); chk("R7 zero write keeps", v, 32'h0020_0000);
        wr(8'h34, 32'h0000_0020);
        rd(8'h34, v); chk("R7 other bit keeps", v, 32'h0020_0000);
        wr(8'h34, 32'h0020_0000);
        rd(8'h34, v); chk("R7 w1c clears", v, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        ext[21] = 0; settle();
        ext[21] = 1; settle();
        ext[21] = 0; settle();
        rd(8'h34, v); chk("R8 pre set", v, 32'h0020_0000);
        ext[21] = 1;
        @(negedge clk); @(negedge clk);
        bus_addr = 8'h34; bus_wdata = 32'h0020_0000; bus_we = 1;
        @(negedge clk);
        bus_we = 0; bus_wdata = '0;
        rd(8'h34, v); chk("R8 edge beats clear", v, 32'h0020_0000);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        chk("R10 gated off", {30'h0, bank_irq}, 32'h0);
        wr(8'h08, 32'h1);
        chk("R9 bank0 idle", {30'h0, bank_irq}, 32'h0);
        wr(8'h08, 32'h3);
        chk("R9 bank1 active", {30'h0, bank_irq}, 32'h2);
        rd(8'h08, v); chk("R10 readback", v, 32'h3);
        wr(8'h24, 32'h10);
        wr(8'h18, 32'h10); settle();
        chk("R9 both banks", {30'h0, bank_irq}, 32'h3);
        wr(8'h08, 32'h2);
        chk("R10 bank0 masked", {30'h0, bank_irq}, 32'h2);
        wr(8'h08, 32'h3);
        wr(8'h34, 32'h0020_0000);
        chk("R9 bank1 cleared", {30'h0, bank_irq}, 32'h1);
        wr(8'h34, 32'h10);
        chk("R9 all clear", {30'h0, bank_irq}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(8'h3C, v); chk("R11 unmapped read", v, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'h0);
        wr(8'h20, 32'h0);
        chk("R11 out unchanged", pin_out, 32'h0000_AF17);
        rd(8'h10, v); chk("R11 dir unchanged", v, 32'hFFFF_0000);
        rd(8'h34, v); chk("R11 status unchanged", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_setclr();
        t_insync();
        t_rise();
        t_fall_both();
        t_w1c();
        t_collision();
        t_irq();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule